// File: doc/BRIEF.md
# Output Compare Channel with Forced Action

This block is one compare channel of a timer. It watches a free-running timer count. On every timer tick it tests whether the count equals a programmed compare value. A real match raises a one-cycle match pulse and updates an output pin according to a two-bit action code. When the channel is the one that sets the period in clear-on-compare operation, the match also asks the counter to clear.

Software can also fire the pin action at once through a force strobe. A forced action moves only the pin. It produces no match pulse and no clear request. When software writes the counter, the next tick's compare is masked so that a value just loaded does not cause a spurious event. The force strobe is a write-only pulse and holds no state of its own. Waveform shaping for PWM operation belongs to a neighbouring block. While the PWM indicator is high, this channel leaves the pin alone.

Top module: `ocmp_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pin_o`, `match_o` and `clr_req_o` are all 0.
- R2: If `tick_i` is high, `cnt_i` equals `cmp_val_i` and no block is pending, `match_o` is 1 in the cycle after that edge. `match_o` is 0 after any edge where `tick_i` is low or the values differ.
- R3: On a match with `pwm_mode_i` low, `act_i` sets the pin action: 2'b00 leaves `pin_o` unchanged, 2'b01 inverts it, 2'b10 drives it to 0 and 2'b11 drives it to 1. The new level appears in the cycle after the edge.
- R4: `clr_req_o` is 1 together with `match_o` exactly when `ctc_top_i` was high and `pwm_mode_i` was low at the matching edge. Otherwise it is 0.
- R5: A `force_i` pulse with `pwm_mode_i` low applies the `act_i` action to `pin_o` in the next cycle. It raises neither `match_o` nor `clr_req_o`, even when `ctc_top_i` is high.
- R6: With `pwm_mode_i` high, `force_i` has no effect on `pin_o`.
- R7: With `pwm_mode_i` high, a match still pulses `match_o`. It leaves `pin_o` unchanged and `clr_req_o` at 0.
- R8: A `cnt_wr_i` pulse masks the compare on the next tick. A tick in the same cycle as the write also counts as that next tick. Only that one tick is masked; later ticks compare normally.
- R9: A pending mask survives any number of cycles without a tick and is used up only by a tick.
- R10: A force and a real match in the same cycle apply the action once, so a toggle inverts `pin_o` a single time. The match still pulses `match_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Current timer count |
| tick_i | input | 1 | Timer count-enable pulse |
| cmp_val_i | input | CNT_W | Compare value |
| act_i | input | 2 | Pin action code on compare |
| pwm_mode_i | input | 1 | Timer is in a PWM waveform mode |
| ctc_top_i | input | 1 | This channel defines the period in clear-on-compare operation |
| force_i | input | 1 | Force strobe: apply pin action now |
| cnt_wr_i | input | 1 | Software wrote the counter |
| pin_o | output | 1 | Compare output pin |
| match_o | output | 1 | One-cycle compare match pulse |
| clr_req_o | output | 1 | Request to clear the counter |

## Verification
The hardest state to reach is a pending mask that has outlived several idle cycles and then meets a tick whose count equals the compare value. This case separates a mask that waits for a tick from one that simply expires after a fixed number of cycles. The bench writes the counter with the tick held low and idles for several cycles. It then presents a tick with an equal count and checks that no match occurs and the pin does not move. A second equal tick must then match. A write in the same cycle as a tick, and a force that coincides with a real toggle match, are driven as separate scenarios.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_INVERT = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } pin_act_e;

  function automatic logic apply_act(input pin_act_e act, input logic cur);
    case (act)
      ACT_INVERT: apply_act = ~cur;
      ACT_LOW:    apply_act = 1'b0;
      ACT_HIGH:   apply_act = 1'b1;
      default:    apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/ocmp_blocker.sv
// Holds the "mask next tick" request raised by a counter write.
module ocmp_blocker (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic cnt_wr_i,
  output logic masked_o
);
  logic pend_q;

  // A write in the current cycle masks a tick in the same cycle.
  assign masked_o = pend_q | cnt_wr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (cnt_wr_i) begin
      pend_q <= ~tick_i;
    end else if (tick_i) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ocmp_detect.sv
// Equality compare qualified by tick and mask; registered match/clear.
module ocmp_detect #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             tick_i,
  input  logic             masked_i,
  input  logic             pwm_mode_i,
  input  logic             ctc_top_i,
  output logic             hit_o,
  output logic             match_o,
  output logic             clr_req_o
);
  logic eq;

  assign eq    = (cnt_i == cmp_val_i);
  assign hit_o = tick_i & eq & ~masked_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o   <= 1'b0;
      clr_req_o <= 1'b0;
    end else begin
      match_o   <= hit_o;
      clr_req_o <= hit_o & ctc_top_i & ~pwm_mode_i;
    end
  end
endmodule

// File: rtl/ocmp_wave.sv
// Pin register: real or forced event applies the action once.
module ocmp_wave
  import ocmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit_i,
  input  logic       force_i,
  input  logic       pwm_mode_i,
  input  logic [1:0] act_i,
  output logic       pin_o
);
  logic evt;

  assign evt = (hit_i | force_i) & ~pwm_mode_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_o <= 1'b0;
    end else if (evt) begin
      pin_o <= apply_act(pin_act_e'(act_i), pin_o);
    end
  end
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic [1:0]       act_i,
  input  logic             pwm_mode_i,
  input  logic             ctc_top_i,
  input  logic             force_i,
  input  logic             cnt_wr_i,
  output logic             pin_o,
  output logic             match_o,
  output logic             clr_req_o
);
  logic masked;
  logic hit;

  ocmp_blocker u_blk (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .cnt_wr_i (cnt_wr_i),
    .masked_o (masked)
  );

  ocmp_detect #(.CNT_W(CNT_W)) u_det (
    .clk        (clk),
    .rst        (rst),
    .cnt_i      (cnt_i),
    .cmp_val_i  (cmp_val_i),
    .tick_i     (tick_i),
    .masked_i   (masked),
    .pwm_mode_i (pwm_mode_i),
    .ctc_top_i  (ctc_top_i),
    .hit_o      (hit),
    .match_o    (match_o),
    .clr_req_o  (clr_req_o)
  );

  ocmp_wave u_wave (
    .clk        (clk),
    .rst        (rst),
    .hit_i      (hit),
    .force_i    (force_i),
    .pwm_mode_i (pwm_mode_i),
    .act_i      (act_i),
    .pin_o      (pin_o)
  );
endmodule

// File: rtl/ocmp_chk.sv
module ocmp_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic [1:0] act_i,
  input logic       pwm_mode_i,
  input logic       force_i,
  input logic       cnt_wr_i,
  input logic       pin_o,
  input logic       match_o,
  input logic       clr_req_o
);
  // R2
  match_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> !match_o);
  // R4
  clr_with_match_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req_o |-> match_o);
  // R8
  write_masks_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_wr_i && tick_i) |=> !match_o);
  // R6
  pwm_pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_mode_i |=> $stable(pin_o));
  // R3
  hold_action_chk: assert property (@(posedge clk) disable iff (rst)
    (act_i == 2'b00) |=> $stable(pin_o));
  // R5
  force_set_chk: assert property (@(posedge clk) disable iff (rst)
    (force_i && !pwm_mode_i && act_i == 2'b11) |=> pin_o);
  // R5
  force_no_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (force_i && !tick_i) |=> !clr_req_o);
endmodule

bind ocmp_unit ocmp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .act_i      (act_i),
  .pwm_mode_i (pwm_mode_i),
  .force_i    (force_i),
  .cnt_wr_i   (cnt_wr_i),
  .pin_o      (pin_o),
  .match_o    (match_o),
  .clr_req_o  (clr_req_o)
);

// File: tb/sim_ocmp_unit.sv
module sim_ocmp_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] cnt_i, cmp_val_i;
  logic         tick_i, pwm_mode_i, ctc_top_i, force_i, cnt_wr_i;
  logic [1:0]   act_i;
  logic         pin_o, match_o, clr_req_o;

  int n_chk = 0;
  int n_bad = 0;
  logic ep;

  always #10 clk = ~clk;

  ocmp_unit #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .tick_i(tick_i),
    .cmp_val_i(cmp_val_i), .act_i(act_i), .pwm_mode_i(pwm_mode_i),
    .ctc_top_i(ctc_top_i), .force_i(force_i), .cnt_wr_i(cnt_wr_i),
    .pin_o(pin_o), .match_o(match_o), .clr_req_o(clr_req_o)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic idle();
    tick_i = 0; force_i = 0; cnt_wr_i = 0;
  endtask

  // one edge, then sample 2 ns after it
  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    rst = 1; idle(); pwm_mode_i = 0; ctc_top_i = 0; act_i = 2'b01;
    cnt_i = 0; cmp_val_i = 100;
    cyc(); cyc();
    chk("R1 pin", pin_o, 0); chk("R1 match", match_o, 0); chk("R1 clr", clr_req_o, 0);
    rst = 0; cyc();
    chk("R1 pin after", pin_o, 0); chk("R1 match after", match_o, 0);
    ep = 0;
  endtask

  task automatic t_match();
    act_i = 2'b01; cnt_i = 100; tick_i = 1; cyc(); tick_i = 0; ep = ~ep;
    chk("R2 match", match_o, 1); chk("R3 invert", pin_o, ep);
    cyc();
    chk("R2 no tick", match_o, 0); chk("R3 held", pin_o, ep);
    cnt_i = 99; tick_i = 1; cyc(); tick_i = 0;
    chk("R2 unequal", match_o, 0); chk("R3 unequal held", pin_o, ep);
  endtask

  task automatic t_modes();
    cnt_i = 100;
    act_i = 2'b10; tick_i = 1; cyc(); ep = 0;
    chk("R3 low", pin_o, ep);
    act_i = 2'b11; cyc(); ep = 1;
    chk("R3 high", pin_o, ep);
    act_i = 2'b00; cyc(); tick_i = 0;
    chk("R3 hold pin", pin_o, ep); chk("R3 hold match", match_o, 1);
  endtask

  task automatic t_ctc();
    ctc_top_i = 1; act_i = 2'b00; cnt_i = 100; tick_i = 1; cyc();
    chk("R4 clr", clr_req_o, 1);
    ctc_top_i = 0; cyc(); tick_i = 0;
    chk("R4 no clr", clr_req_o, 0); chk("R4 match", match_o, 1);
  endtask

  task automatic t_force();
    ctc_top_i = 1; act_i = 2'b01; cnt_i = 100; force_i = 1; cyc(); force_i = 0; ep = ~ep;
    chk("R5 force invert", pin_o, ep); chk("R5 no match", match_o, 0);
    chk("R5 no clr", clr_req_o, 0);
    act_i = 2'b10; force_i = 1; cyc(); force_i = 0; ep = 0;
    chk("R5 force low", pin_o, ep);
    ctc_top_i = 0;
  endtask

  task automatic t_pwm();
    pwm_mode_i = 1; ctc_top_i = 1; act_i = 2'b11;
    force_i = 1; cyc(); force_i = 0;
    chk("R6 force ignored", pin_o, ep);
    cnt_i = 100; tick_i = 1; cyc(); tick_i = 0;
    chk("R7 match", match_o, 1); chk("R7 pin", pin_o, ep); chk("R7 clr", clr_req_o, 0);
    pwm_mode_i = 0; ctc_top_i = 0;
  endtask

  task automatic t_block();
    act_i = 2'b01; cnt_i = 100;
    cnt_wr_i = 1; cyc(); cnt_wr_i = 0;
    for (int i = 0; i < 4; i++) cyc();
    chk("R9 idle", match_o, 0);
    tick_i = 1; cyc(); tick_i = 0;
    chk("R8 masked", match_o, 0); chk("R9 pin", pin_o, ep);
    tick_i = 1; cyc(); tick_i = 0; ep = ~ep;
    chk("R8 next tick", match_o, 1); chk("R8 pin", pin_o, ep);
    cnt_wr_i = 1; tick_i = 1; cyc(); cnt_wr_i = 0;
    chk("R8 same cycle", match_o, 0);
    cyc(); tick_i = 0; ep = ~ep;
    chk("R8 after same", match_o, 1); chk("R8 pin after", pin_o, ep);
  endtask

  task automatic t_both();
    act_i = 2'b01; cnt_i = 100; tick_i = 1; force_i = 1; cyc(); idle(); ep = ~ep;
    chk("R10 once", pin_o, ep); chk("R10 match", match_o, 1);
  endtask

  initial begin
    t_reset(); t_match(); t_modes(); t_ctc(); t_force();
    t_pwm(); t_block(); t_both();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule